// File: doc/BRIEF.md
# Segmented Physical Address Generator

This unit turns a 16-bit offset into a 20-bit physical memory address. It holds four 16-bit segment bases: code, data, stack and extra. On each request the unit looks at which pointer register produced the offset and picks a default segment from it. A segment-override request can replace that default where the rules permit. The chosen base is shifted left by four bits and added to the offset. The sum wraps inside the 1 MB space, from 00000h to FFFFFh.

Requests are single-cycle strobes. The address appears, registered, on the cycle after the strobe, together with a valid flag. A write port loads any one segment base per cycle. The new value is used by requests from the next cycle on.

A two-state control machine runs the output side:
- `ST_IDLE`: no result is pending and `addr_valid` is low.
- `ST_DONE`: a result was captured at the last edge and `addr_valid` is high.

It has four transitions:
- `IDLE->DONE`: taken when `req` is high.
- `DONE->DONE`: taken when another `req` follows back to back.
- `DONE->IDLE`: taken when no `req` follows.
- `IDLE->IDLE`: taken while no request arrives.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset, `addr_valid` is 0, `addr_out` is 00000h and all four segment bases are 0000h. A request made before any write therefore returns the offset unchanged.
- R2: The physical address is (segment × 16 + offset) modulo 2^20. A sum above FFFFFh wraps to the bottom of the space.
- R3: Pointer code 0 (instruction pointer) always uses the code segment. It ignores any override.
- R4: Pointer codes 1 (stack pointer) and 2 (base pointer) default to the stack segment.
- R5: Pointer codes 3 (source index), 5 (base register), 6 (direct) and 7 (spare) default to the data segment.
- R6: Pointer code 4 (destination index) uses the extra segment, ignoring any override, when `str_dst` is 1. When `str_dst` is 0 it defaults to the data segment.
- R7: When `ovr_valid` is 1, `ovr_seg` replaces the default segment for every access not fixed by R3 or R6. Segment codes are 0 code, 1 data, 2 stack, 3 extra.
- R8: `addr_valid` is 1 in exactly the cycles that follow a cycle with `req` high. `addr_out` holds its value when no request was made.
- R9: A segment write issued in the same cycle as a request does not affect that request. The new value applies to requests from the next cycle on.
- R10: A segment write changes only the base selected by `seg_wsel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_we | input | 1 | Segment base write enable |
| seg_wsel | input | 2 | Segment code to write (0 code, 1 data, 2 stack, 3 extra) |
| seg_wdata | input | 16 | New segment base value |
| req | input | 1 | Address request strobe |
| offset | input | 16 | Offset of the access |
| base_sel | input | 3 | Pointer code that produced the offset |
| str_dst | input | 1 | Access is a string destination |
| ovr_valid | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment code |
| addr_out | output | 20 | Registered physical address |
| addr_valid | output | 1 | `addr_out` holds a fresh result this cycle |

## Verification
The segment bases are loaded with distinct values, 1000h, 2000h, 3000h and 4000h. Each pointer code is then issued with and without an override. The resulting address alone shows which segment was chosen, so it separates a wrong default from an override that was wrongly taken or wrongly refused. The destination index is run with the string flag both set and clear. A data base of FFFFh is combined with small and full-scale offsets to expose a missing wrap at 20 bits. A write and a request in the same cycle, followed by a request alone, tell old-value from new-value timing. Back-to-back and isolated strobes show whether the valid flag and the held address follow the request pattern.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;

    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_e;

    typedef enum logic [2:0] {
        PTR_IP     = 3'd0,
        PTR_SP     = 3'd1,
        PTR_BP     = 3'd2,
        PTR_SI     = 3'd3,
        PTR_DI     = 3'd4,
        PTR_BX     = 3'd5,
        PTR_DIRECT = 3'd6,
        PTR_SPARE  = 3'd7
    } ptr_id_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } agu_state_e;

    localparam int SEG_COUNT = 4;

endpackage

// File: rtl/seg_base_file.sv
module seg_base_file #(
    parameter int DATA_W = 16,
    parameter int NUM_SEG = 4,
    localparam int SEL_W = $clog2(NUM_SEG)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [SEL_W-1:0]                 wr_sel,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [NUM_SEG-1:0][DATA_W-1:0]   bases
);

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_base
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bases[g] <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                bases[g] <= wr_data;
            end
        end
    end

    // R9: a write is visible on the following cycle
    assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> bases[$past(wr_sel)] == $past(wr_data));

    // R10: without a write every base keeps its value
    assert_bases_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bases));

endmodule

// File: rtl/seg_pick.sv
module seg_pick
    import seg_agu_pkg::*;
(
    input  ptr_id_e  ptr,
    input  logic     str_dst,
    input  logic     ovr_valid,
    input  seg_id_e  ovr_seg,
    output seg_id_e  chosen
);

    seg_id_e dflt;
    logic    locked;

    always_comb begin
        dflt   = SEG_DATA;
        locked = 1'b0;
        unique case (ptr)
            PTR_IP: begin
                dflt   = SEG_CODE;
                locked = 1'b1;
            end
            PTR_SP, PTR_BP: dflt = SEG_STACK;
            PTR_DI: begin
                if (str_dst) begin
                    dflt   = SEG_EXTRA;
                    locked = 1'b1;
                end else begin
                    dflt = SEG_DATA;
                end
            end
            PTR_SI, PTR_BX, PTR_DIRECT, PTR_SPARE: dflt = SEG_DATA;
        endcase
    end

    always_comb begin
        chosen = (ovr_valid && !locked) ? ovr_seg : dflt;
    end

    // R3: instruction fetches stay in the code segment
    always_comb begin
        if (ptr == PTR_IP) begin
            assert_ip_code_R3: assert (chosen == SEG_CODE);
        end
    end

endmodule

// File: rtl/seg_addr_add.sv
module seg_addr_add #(
    parameter int OFS_W = 16,
    parameter int SHIFT = 4,
    localparam int AW = OFS_W + SHIFT
) (
    input  logic [OFS_W-1:0] seg_base,
    input  logic [OFS_W-1:0] ofs,
    output logic [AW-1:0]    phys
);

    logic [AW-1:0] shifted;
    logic [AW-1:0] widened;

    always_comb begin
        shifted = {seg_base, {SHIFT{1'b0}}};
        widened = {{SHIFT{1'b0}}, ofs};
        phys    = shifted + widened;
    end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_agu_pkg::*;
#(
    parameter int OFS_W = 16,
    parameter int SHIFT = 4,
    localparam int AW = OFS_W + SHIFT,
    localparam int SEL_W = $clog2(SEG_COUNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seg_we,
    input  logic [SEL_W-1:0] seg_wsel,
    input  logic [OFS_W-1:0] seg_wdata,
    input  logic             req,
    input  logic [OFS_W-1:0] offset,
    input  logic [2:0]       base_sel,
    input  logic             str_dst,
    input  logic             ovr_valid,
    input  logic [SEL_W-1:0] ovr_seg,
    output logic [AW-1:0]    addr_out,
    output logic             addr_valid
);

    logic [SEG_COUNT-1:0][OFS_W-1:0] bases;
    seg_id_e                         pick;
    logic [OFS_W-1:0]                base_val;
    logic [AW-1:0]                   phys_d;
    agu_state_e                      state, state_nx;

    seg_base_file #(.DATA_W(OFS_W), .NUM_SEG(SEG_COUNT)) u_bases (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_we),
        .wr_sel  (seg_wsel),
        .wr_data (seg_wdata),
        .bases   (bases)
    );

    seg_pick u_pick (
        .ptr       (ptr_id_e'(base_sel)),
        .str_dst   (str_dst),
        .ovr_valid (ovr_valid),
        .ovr_seg   (seg_id_e'(ovr_seg)),
        .chosen    (pick)
    );

    always_comb begin
        base_val = bases[pick];
    end

    seg_addr_add #(.OFS_W(OFS_W), .SHIFT(SHIFT)) u_add (
        .seg_base (base_val),
        .ofs      (offset),
        .phys     (phys_d)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = req ? ST_DONE : ST_IDLE;
            ST_DONE: state_nx = req ? ST_DONE : ST_IDLE;
        endcase
    end

    // address capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_out <= '0;
        end else if (req) begin
            addr_out <= phys_d;
        end
    end

    // outputs
    always_comb begin
        addr_valid = (state == ST_DONE);
    end

    assert_valid_after_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> addr_valid);

    assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !addr_valid);

    assert_hold_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> $stable(addr_out));

    assert_ip_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && base_sel == 3'(PTR_IP)) |=>
            addr_out == AW'({$past(bases[0]), {SHIFT{1'b0}}}) + AW'($past(offset)));

    assert_strdst_extra_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && base_sel == 3'(PTR_DI) && str_dst) |=>
            addr_out == AW'({$past(bases[3]), {SHIFT{1'b0}}}) + AW'($past(offset)));

endmodule

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_we = 1'b0;
    logic [1:0]  seg_wsel = '0;
    logic [15:0] seg_wdata = '0;
    logic        req = 1'b0;
    logic [15:0] offset = '0;
    logic [2:0]  base_sel = '0;
    logic        str_dst = 1'b0;
    logic        ovr_valid = 1'b0;
    logic [1:0]  ovr_seg = '0;
    logic [19:0] addr_out;
    logic        addr_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit started = 1'b0;
    logic [19:0] last_addr = '0;
    logic [15:0] model [4];
    logic [19:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    seg_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_wsel(seg_wsel),
        .seg_wdata(seg_wdata), .req(req), .offset(offset), .base_sel(base_sel),
        .str_dst(str_dst), .ovr_valid(ovr_valid), .ovr_seg(ovr_seg),
        .addr_out(addr_out), .addr_valid(addr_valid)
    );

    task automatic chk(input bit ok, input string tag, input logic [19:0] act,
                       input logic [19:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
        end
    endtask

    function automatic int pick_seg(input logic [2:0] b, input bit s,
                                    input bit ov, input logic [1:0] os);
        if (b == 3'd0) return 0;
        if (b == 3'd4 && s) return 3;
        if (ov) return int'(os);
        if (b == 3'd1 || b == 3'd2) return 2;
        return 1;
    endfunction

    function automatic logic [19:0] phys(input logic [15:0] sg, input logic [15:0] of);
        logic [20:0] full;
        full = {1'b0, sg, 4'h0} + {5'h0, of};
        return full[19:0];
    endfunction

    task automatic set_req(input logic [15:0] of, input logic [2:0] b, input bit s,
                           input bit ov, input logic [1:0] os, input string tag);
        exp_q.push_back(phys(model[pick_seg(b, s, ov, os)], of));
        tag_q.push_back(tag);
        req = 1'b1; offset = of; base_sel = b; str_dst = s;
        ovr_valid = ov; ovr_seg = os;
    endtask

    task automatic issue(input logic [15:0] of, input logic [2:0] b, input bit s,
                         input bit ov, input logic [1:0] os, input string tag);
        set_req(of, b, s, ov, os, tag);
        @(negedge clk);
        req = 1'b0; ovr_valid = 1'b0; str_dst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        seg_we = 1'b1; seg_wsel = sel; seg_wdata = d;
        @(negedge clk);
        seg_we = 1'b0;
        model[sel] = d;
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (exp_q.size() > 0) begin
                logic [19:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(addr_valid === 1'b1 && addr_out === e, t, addr_out, e);
                started = 1'b1;
            end else if (addr_valid) begin
                chk(1'b0, "R8 valid without request", addr_out, last_addr);
            end else if (started) begin
                chk(addr_out === last_addr, "R8 hold when idle", addr_out, last_addr);
            end
            last_addr = addr_out;
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%05h expected=%05h", addr_out, 20'h0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) model[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(addr_valid === 1'b0, "R1 valid low after reset", {19'h0, addr_valid}, 20'h0);
        chk(addr_out === 20'h0, "R1 address zero after reset", addr_out, 20'h0);
        issue(16'h1234, 3'd3, 0, 0, 2'd0, "R1 zero data base");
        issue(16'hBEEF, 3'd1, 0, 0, 2'd0, "R1 zero stack base");
        @(negedge clk);

        wr(2'd0, 16'h1000);
        wr(2'd1, 16'h2000);
        wr(2'd2, 16'h3000);
        wr(2'd3, 16'h4000);

        issue(16'h0010, 3'd0, 0, 0, 2'd0, "R3 ip code");
        issue(16'h0010, 3'd0, 0, 1, 2'd1, "R3 ip override ignored");
        issue(16'h0100, 3'd1, 0, 0, 2'd0, "R4 sp stack");
        issue(16'h0200, 3'd2, 0, 0, 2'd0, "R4 bp stack");
        issue(16'h0300, 3'd2, 0, 1, 2'd3, "R7 bp override extra");
        issue(16'h0400, 3'd3, 0, 0, 2'd0, "R5 si data");
        issue(16'h0500, 3'd5, 0, 0, 2'd0, "R5 bx data");
        issue(16'h0600, 3'd6, 0, 0, 2'd0, "R5 direct data");
        issue(16'h0650, 3'd7, 0, 0, 2'd0, "R5 spare data");
        issue(16'h0700, 3'd6, 0, 1, 2'd2, "R7 direct override stack");
        issue(16'h0800, 3'd3, 0, 1, 2'd0, "R7 si override code");
        issue(16'h0900, 3'd4, 1, 0, 2'd0, "R6 di string extra");
        issue(16'h0A00, 3'd4, 1, 1, 2'd0, "R6 di string override ignored");
        issue(16'h0B00, 3'd4, 0, 0, 2'd0, "R6 di plain data");
        issue(16'h0C00, 3'd4, 0, 1, 2'd2, "R7 di plain override stack");
        @(negedge clk);

        wr(2'd3, 16'h7777);
        issue(16'h0001, 3'd1, 0, 0, 2'd0, "R10 stack unchanged");
        issue(16'h0002, 3'd0, 0, 0, 2'd0, "R10 code unchanged");
        issue(16'h0003, 3'd3, 0, 0, 2'd0, "R10 data unchanged");
        issue(16'h0004, 3'd4, 1, 0, 2'd0, "R10 extra updated");

        wr(2'd1, 16'hFFFF);
        issue(16'h0020, 3'd3, 0, 0, 2'd0, "R2 wrap small");
        issue(16'hFFFF, 3'd3, 0, 0, 2'd0, "R2 wrap full");
        issue(16'h000F, 3'd3, 0, 0, 2'd0, "R2 top of space");
        @(negedge clk);
        @(negedge clk);

        // write and request in the same cycle
        seg_we = 1'b1; seg_wsel = 2'd1; seg_wdata = 16'h5000;
        set_req(16'h0042, 3'd3, 0, 0, 2'd0, "R9 same cycle old base");
        @(negedge clk);
        seg_we = 1'b0; req = 1'b0;
        model[1] = 16'h5000;
        issue(16'h0042, 3'd3, 0, 0, 2'd0, "R9 next cycle new base");
        @(negedge clk);
        issue(16'h0011, 3'd2, 0, 0, 2'd0, "R8 isolated");
        @(negedge clk);
        @(negedge clk);
        repeat (4) @(negedge clk);

        chk(exp_q.size() == 0, "R8 all results delivered", 20'(exp_q.size()), 20'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule